// File: doc/BRIEF.md
# SPI Master FIFO Event and Interrupt Unit

This unit sits between a host register port and the serial shifter of an SPI master. It holds two byte-wide queues. The transmit queue is filled by the host one 32-bit word at a time and drained by the shifter one byte at a time. The receive queue is filled by the shifter one byte at a time and drained by the host, either four bytes per word read or one byte per byte read. Byte reads let software collect a tail of one to three bytes that does not fill a word.

Software watches the queues through an event word. The event word shows live byte counts for both queues, a receive-holds-data flag, a transmit-has-room flag and an underflow flag. The event flags are write-one-to-clear. A mask word selects which flags may raise the interrupt line. A mode word holds a transmit threshold and a receive threshold for software use. Serial shifting and clock generation live outside this unit.

Host accesses use a 3-bit select: 0 mode, 1 event, 2 mask, 3 transmit port, 4 receive port. Read data is combinational from the select. A receive-port read removes bytes at the clock edge that ends the read cycle.

Top module: `spi_fifo_evt`

## Requirements
- R1: After reset both byte counts are 0, the mask word reads 0, the interrupt is low and the shifter sees no transmit data. From the first clock after reset the event word reads 0x0000_0100, because the transmit-has-room flag (bit 8) is set.
- R2: A host write to the transmit port queues the four bytes of the word, bits 31:24 first. The transmit count in event bits 21:16 rises by 4 in the cycle of the write. The shifter receives the bytes in that order on `txb_data`, and each `txb_pop` removes one byte.
- R3: A transmit-port write made while fewer than 4 bytes are free is dropped and leaves the transmit count unchanged. The transmit-has-room condition (bit 8) holds only while at least 4 bytes are free.
- R4: Each `rxb_push` queues one byte, and the receive count in event bits 29:24 rises by 1 in the same cycle. One cycle later the receive-holds-data flag (event bit 9) is set.
- R5: A word read of the receive port with at least 4 bytes queued returns them oldest-first in bits 31:24 down to 7:0 and removes four bytes.
- R6: A byte read of the receive port (`host_byte` = 1) returns the oldest byte in bits 7:0 with zeros above, and removes one byte.
- R7: A word read of the receive port with fewer than 4 bytes queued returns 0 and removes nothing. It sets the underflow flag (event bit 11). A byte read of an empty receive queue also returns 0 and sets the same flag.
- R8: Writing ones to the event word clears those flags. A flag whose condition still holds stays set, so after writing all ones only the live conditions remain.
- R9: The mask word keeps bits 11, 9 and 8 and reads 0 elsewhere. `irq` goes high exactly one cycle after an event flag and its mask bit are both set.
- R10: The mode word holds the transmit threshold in bits 13:8 and the receive threshold in bits 5:0, with reset values 4 and 3 (0x0000_0403). Its other bits read 0.
- R11: A receive push made while the receive queue holds 32 bytes is dropped. A `txb_pop` made while the transmit queue is empty is ignored, and `txb_avail` is low while the transmit queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (a receive-port read removes bytes) |
| host_sel | input | 3 | Register select: 0 mode, 1 event, 2 mask, 3 transmit port, 4 receive port |
| host_byte | input | 1 | Receive-port read is a single-byte access |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for the selected register |
| txb_pop | input | 1 | Shifter takes one transmit byte |
| txb_data | output | 8 | Oldest transmit byte |
| txb_avail | output | 1 | Transmit queue holds at least one byte |
| rxb_push | input | 1 | Shifter delivers one received byte |
| rxb_data | input | 8 | Received byte |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default depth of 32 bytes per queue. At that depth eight word writes fill the transmit queue and 33 byte pushes overrun the receive queue, so both full-queue drop rules and the loss of the transmit-has-room flag can be tested in a few hundred cycles. The tests also cover word reads that straddle a short tail and byte draining of that tail. They count the exact two-cycle latency from a receive push to the interrupt.

// File: rtl/spi_fifo_evt_pkg.sv
package spi_fifo_evt_pkg;

    typedef enum logic [2:0] {
        SEL_MODE   = 3'd0,
        SEL_EVENT  = 3'd1,
        SEL_MASK   = 3'd2,
        SEL_TXPORT = 3'd3,
        SEL_RXPORT = 3'd4
    } reg_sel_e;

    localparam int CNT_FIELD_W = 6;
    localparam int BIT_TX_ROOM = 8;
    localparam int BIT_RX_DATA = 9;
    localparam int BIT_UFLOW   = 11;
    localparam int THR_W       = 6;

    typedef struct packed {
        logic [THR_W-1:0] tx_thr;
        logic [THR_W-1:0] rx_thr;
        logic             f_rx;
        logic             f_tx;
        logic             f_uf;
        logic             m_rx;
        logic             m_tx;
        logic             m_uf;
        logic             irq;
    } evt_state_t;

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DEPTH = 32,
    parameter int CW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    push_n,
    input  logic [31:0]   push_word,
    input  logic [2:0]    pop_n,
    output logic [31:0]   head_word,
    output logic [CW-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic [7:0]  mem_q [DEPTH];

    function automatic logic [AW-1:0] wrap(input logic [AW-1:0] p, input logic [2:0] n);
        int s;
        s = int'(p) + int'(n);
        if (s >= DEPTH) s = s - DEPTH;
        return AW'(s);
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.wp  = wrap(st_q.wp, push_n);
        st_d.rp  = wrap(st_q.rp, pop_n);
        st_d.cnt = st_q.cnt + CW'(push_n) - CW'(pop_n);
        for (int i = 0; i < 4; i++) begin
            head_word[31-8*i -: 8] = (CW'(i) < st_q.cnt) ? mem_q[wrap(st_q.rp, 3'(i))] : 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (3'(i) < push_n) begin
                mem_q[wrap(st_q.wp, 3'(i))] <= push_word[31-8*i -: 8];
            end
        end
    end

    assign count = st_q.cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.cnt) <= DEPTH); // R11
    AST_POP_COVERED: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(pop_n) <= st_q.cnt); // R5
    AST_PUSH_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.cnt) + int'(push_n) <= DEPTH); // R3

endmodule

// File: rtl/evt_regs.sv
module evt_regs
    import spi_fifo_evt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_mode,
    input  logic        wr_event,
    input  logic        wr_mask,
    input  logic [31:0] wdata,
    input  logic        rx_has_data,
    input  logic        tx_has_room,
    input  logic        uflow_hit,
    output evt_state_t  st
);
    evt_state_t st_d, st_q;
    logic clr_rx, clr_tx, clr_uf;

    always_comb begin
        st_d   = st_q;
        clr_rx = wr_event & wdata[BIT_RX_DATA];
        clr_tx = wr_event & wdata[BIT_TX_ROOM];
        clr_uf = wr_event & wdata[BIT_UFLOW];
        if (wr_mode) begin
            st_d.tx_thr = wdata[8 +: THR_W];
            st_d.rx_thr = wdata[0 +: THR_W];
        end
        if (wr_mask) begin
            st_d.m_rx = wdata[BIT_RX_DATA];
            st_d.m_tx = wdata[BIT_TX_ROOM];
            st_d.m_uf = wdata[BIT_UFLOW];
        end
        st_d.f_rx = (st_q.f_rx & ~clr_rx) | rx_has_data;
        st_d.f_tx = (st_q.f_tx & ~clr_tx) | tx_has_room;
        st_d.f_uf = (st_q.f_uf & ~clr_uf) | uflow_hit;
        st_d.irq  = (st_q.f_rx & st_q.m_rx) | (st_q.f_tx & st_q.m_tx) | (st_q.f_uf & st_q.m_uf);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.tx_thr <= THR_W'(4);
            st_q.rx_thr <= THR_W'(3);
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> $past(st_q.m_rx | st_q.m_tx | st_q.m_uf)); // R9
    AST_UFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.f_uf && !wr_event) |=> st_q.f_uf); // R8

endmodule

// File: rtl/spi_fifo_evt.sv
module spi_fifo_evt
    import spi_fifo_evt_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [2:0]  host_sel,
    input  logic        host_byte,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    input  logic        txb_pop,
    output logic [7:0]  txb_data,
    output logic        txb_avail,
    input  logic        rxb_push,
    input  logic [7:0]  rxb_data,
    output logic        irq
);
    localparam int CW = CNT_FIELD_W;

    logic [2:0]    tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
    logic [31:0]   tx_head, rx_head, rx_push_word;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic          tx_room, rx_full, uflow_hit;
    logic          rd_rx, wr_tx;
    logic [31:0]   rx_port_data;
    evt_state_t    ev;

    byte_fifo #(.DEPTH(DEPTH), .CW(CW)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push_n(tx_push_n), .push_word(host_wdata),
        .pop_n(tx_pop_n), .head_word(tx_head), .count(tx_cnt)
    );

    byte_fifo #(.DEPTH(DEPTH), .CW(CW)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push_n(rx_push_n), .push_word(rx_push_word),
        .pop_n(rx_pop_n), .head_word(rx_head), .count(rx_cnt)
    );

    evt_regs u_evt (
        .clk(clk), .rst_n(rst_n),
        .wr_mode(host_wr && host_sel == SEL_MODE),
        .wr_event(host_wr && host_sel == SEL_EVENT),
        .wr_mask(host_wr && host_sel == SEL_MASK),
        .wdata(host_wdata),
        .rx_has_data(rx_cnt != '0),
        .tx_has_room(tx_room),
        .uflow_hit(uflow_hit),
        .st(ev)
    );

    always_comb begin
        tx_room      = (int'(tx_cnt) + 4) <= DEPTH;
        rx_full      = int'(rx_cnt) >= DEPTH;
        wr_tx        = host_wr && host_sel == SEL_TXPORT;
        rd_rx        = host_rd && host_sel == SEL_RXPORT;
        tx_push_n    = (wr_tx && tx_room) ? 3'd4 : 3'd0;
        tx_pop_n     = (txb_pop && tx_cnt != '0) ? 3'd1 : 3'd0;
        rx_push_n    = (rxb_push && !rx_full) ? 3'd1 : 3'd0;
        rx_push_word = {rxb_data, 24'h000000};
        rx_pop_n     = 3'd0;
        uflow_hit    = 1'b0;
        rx_port_data = 32'h0;
        if (host_byte) begin
            if (rx_cnt != '0) begin
                rx_port_data = {24'h000000, rx_head[31:24]};
                rx_pop_n     = rd_rx ? 3'd1 : 3'd0;
            end else begin
                uflow_hit = rd_rx;
            end
        end else begin
            if (rx_cnt >= CW'(4)) begin
                rx_port_data = rx_head;
                rx_pop_n     = rd_rx ? 3'd4 : 3'd0;
            end else begin
                uflow_hit = rd_rx;
            end
        end
        case (host_sel)
            SEL_MODE:   host_rdata = {18'h0, ev.tx_thr, 2'b00, ev.rx_thr};
            SEL_EVENT:  host_rdata = {2'b00, rx_cnt, 2'b00, tx_cnt, 4'h0,
                                      ev.f_uf, 1'b0, ev.f_rx, ev.f_tx, 8'h00};
            SEL_MASK:   host_rdata = {20'h0, ev.m_uf, 1'b0, ev.m_rx, ev.m_tx, 8'h00};
            SEL_RXPORT: host_rdata = rx_port_data;
            default:    host_rdata = 32'h0;
        endcase
    end

    assign txb_data  = tx_head[31:24];
    assign txb_avail = tx_cnt != '0;
    assign irq       = ev.irq;

    AST_TX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tx && int'(tx_cnt) > DEPTH - 4) |=> tx_cnt <= $past(tx_cnt)); // R3
    AST_UFLOW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && !host_byte && rx_cnt < CW'(4)) |=> ev.f_uf); // R7
    AST_RX_FLAG_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt != '0) |=> ev.f_rx); // R4
    AST_TX_AVAIL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (txb_pop && !txb_avail) |=> tx_cnt <= CW'(4)); // R11

endmodule

// File: tb/spi_fifo_evt_bench.sv
module spi_fifo_evt_bench;
    import spi_fifo_evt_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0, host_byte = 1'b0;
    logic [2:0]  host_sel = 3'd0;
    logic [31:0] host_wdata = 32'h0;
    logic [31:0] host_rdata;
    logic        txb_pop = 1'b0, rxb_push = 1'b0;
    logic [7:0]  txb_data, rxb_data = 8'h0;
    logic        txb_avail, irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    spi_fifo_evt u_spi_fifo_evt (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel),
        .host_byte(host_byte), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .txb_pop(txb_pop), .txb_data(txb_data), .txb_avail(txb_avail),
        .rxb_push(rxb_push), .rxb_data(rxb_data), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hwrite(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        host_sel = sel; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [2:0] sel, input logic bytewise, output logic [31:0] d);
        @(negedge clk);
        host_sel = sel; host_byte = bytewise; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0; host_byte = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] b);
        @(negedge clk);
        rxb_data = b; rxb_push = 1'b1;
        @(negedge clk);
        rxb_push = 1'b0;
    endtask

    task automatic tx_pop();
        @(negedge clk);
        txb_pop = 1'b1;
        @(negedge clk);
        txb_pop = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        idle(2);
        hread(SEL_EVENT, 1'b0, d); check("R1 event after reset", d, 32'h0000_0100);
        hread(SEL_MASK, 1'b0, d);  check("R1 mask after reset", d, 32'h0);
        check("R1 irq low", {31'h0, irq}, 32'h0);
        check("R1 txb_avail low", {31'h0, txb_avail}, 32'h0);
        hread(SEL_MODE, 1'b0, d);  check("R10 mode reset", d, 32'h0000_0403);
    endtask

    task automatic t_mode();
        logic [31:0] d;
        hwrite(SEL_MODE, 32'h0000_1502);
        hread(SEL_MODE, 1'b0, d); check("R10 mode write", d, 32'h0000_1502);
        hwrite(SEL_MODE, 32'hFFFF_FFFF);
        hread(SEL_MODE, 1'b0, d); check("R10 mode fields only", d, 32'h0000_3F3F);
    endtask

    task automatic t_tx();
        logic [31:0] d;
        hwrite(SEL_TXPORT, 32'hA1B2C3D4);
        hread(SEL_EVENT, 1'b0, d); check("R2 tx count 4", d, 32'h0004_0100);
        check("R2 avail", {31'h0, txb_avail}, 32'h1);
        check("R2 byte0", {24'h0, txb_data}, 32'hA1);
        tx_pop(); check("R2 byte1", {24'h0, txb_data}, 32'hB2);
        tx_pop(); check("R2 byte2", {24'h0, txb_data}, 32'hC3);
        tx_pop(); check("R2 byte3", {24'h0, txb_data}, 32'hD4);
        tx_pop(); check("R11 avail after drain", {31'h0, txb_avail}, 32'h0);
        tx_pop();
        hread(SEL_EVENT, 1'b0, d); check("R11 pop on empty ignored", d, 32'h0000_0100);
    endtask

    task automatic t_tx_full();
        logic [31:0] d;
        for (int i = 0; i < 8; i++) begin
            hwrite(SEL_TXPORT, {8'(4*i), 8'(4*i+1), 8'(4*i+2), 8'(4*i+3)});
        end
        hwrite(SEL_EVENT, 32'h0000_0100);
        idle(1);
        hread(SEL_EVENT, 1'b0, d); check("R3 full, room flag clears", d, 32'h0020_0000);
        hwrite(SEL_TXPORT, 32'hDEADBEEF);
        hread(SEL_EVENT, 1'b0, d); check("R3 write dropped when full", d, 32'h0020_0000);
        for (int i = 0; i < 4; i++) tx_pop();
        idle(1);
        hread(SEL_EVENT, 1'b0, d); check("R3 room returns at 28", d, 32'h001C_0100);
        for (int i = 0; i < 27; i++) tx_pop();
        check("R2 last queued byte", {24'h0, txb_data}, 32'h1F);
        tx_pop();
        check("R11 drained", {31'h0, txb_avail}, 32'h0);
    endtask

    task automatic t_rx();
        logic [31:0] d;
        rx_push(8'h11); rx_push(8'h22); rx_push(8'h33); rx_push(8'h44); rx_push(8'h55);
        idle(1);
        hread(SEL_EVENT, 1'b0, d); check("R4 rx count 5 and flag", d, 32'h0500_0300);
        hread(SEL_RXPORT, 1'b0, d); check("R5 word read", d, 32'h1122_3344);
        hread(SEL_RXPORT, 1'b1, d); check("R6 byte tail", d, 32'h0000_0055);
        hwrite(SEL_EVENT, 32'h0000_0200);
        hread(SEL_EVENT, 1'b0, d); check("R8 data flag cleared", d, 32'h0000_0100);
    endtask

    task automatic t_uflow();
        logic [31:0] d;
        rx_push(8'hAA); rx_push(8'hBB);
        hread(SEL_RXPORT, 1'b0, d); check("R7 short word read returns 0", d, 32'h0);
        idle(1);
        hread(SEL_EVENT, 1'b0, d); check("R7 underflow, nothing removed", d, 32'h0200_0B00);
        hread(SEL_RXPORT, 1'b1, d); check("R6 byte AA", d, 32'h0000_00AA);
        hread(SEL_RXPORT, 1'b1, d); check("R6 byte BB", d, 32'h0000_00BB);
        hread(SEL_RXPORT, 1'b1, d); check("R7 byte read empty", d, 32'h0);
        hwrite(SEL_EVENT, 32'hFFFF_FFFF);
        hread(SEL_EVENT, 1'b0, d); check("R8 clear all keeps live room flag", d, 32'h0000_0100);
    endtask

    task automatic t_rx_full();
        logic [31:0] d;
        for (int i = 0; i < 33; i++) rx_push(8'(i));
        hread(SEL_EVENT, 1'b0, d); check("R11 rx count capped at 32", d[29:24], 32'h20);
        for (int i = 0; i < 8; i++) begin
            hread(SEL_RXPORT, 1'b0, d);
            check("R5 full drain word", d, {8'(4*i), 8'(4*i+1), 8'(4*i+2), 8'(4*i+3)});
        end
        hread(SEL_EVENT, 1'b0, d); check("R11 overrun byte dropped", d[29:24], 32'h0);
        hwrite(SEL_EVENT, 32'h0000_0200);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        check("R9 irq low unmasked", {31'h0, irq}, 32'h0);
        hwrite(SEL_MASK, 32'hFFFF_FFFF);
        hread(SEL_MASK, 1'b0, d); check("R9 mask bits", d, 32'h0000_0B00);
        check("R9 irq from room flag", {31'h0, irq}, 32'h1);
        hwrite(SEL_MASK, 32'h0000_0200);
        idle(1);
        check("R9 irq drops when unmasked", {31'h0, irq}, 32'h0);
        rx_push(8'h77);
        check("R9 irq not yet (count only)", {31'h0, irq}, 32'h0);
        idle(1);
        check("R9 irq not yet (flag only)", {31'h0, irq}, 32'h0);
        idle(1);
        check("R9 irq after flag and mask", {31'h0, irq}, 32'h1);
        hwrite(SEL_MASK, 32'h0);
        hread(SEL_RXPORT, 1'b1, d); check("R6 byte 77", d, 32'h0000_0077);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_mode();
        t_tx();
        t_tx_full();
        t_rx();
        t_uflow();
        t_rx_full();
        t_irq();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule